// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block is a bus-slave register bank with a fixed map of four registers, addressed in bus words. One register is a pass-through: a bus write to it is handed to the core as a data word plus a single-cycle strobe, and a bus read of it returns whatever the core drives on a dedicated input. The other three registers are held inside the bank. Each of them has its own access policy on the bus side and its own policy on the core side, and each policy is read-only, write-only or read-write.

A held register wider than the bus word is split across consecutive addresses. Its most significant word sits at the lowest of those addresses. The bus has no handshake. An address and a write enable are presented in one cycle, and read data for that address appears on the next cycle. The map has four entries. The pass-through register sits at address 0. A 20-bit configuration value occupies addresses 1 to 3; the bus may read and write it, and the core may only read it. An 8-bit status value sits at address 4; the core may only write it, and the bus may only read it. An 8-bit control value sits at address 5; the bus may only write it, and the core may read and write it.

Top module: `csr_bank`

## Requirements
- R1: `bus_rdat` is registered. In the cycle after an address is presented, it shows the content of that address as it stood when the address was presented. Addresses 6 to 15 read as zero.
- R2: A bus write to address 0 raises `raw_stb` for exactly the next cycle, with `raw_wdat` equal to the written word in that cycle. When there is no such write, `raw_stb` is low in the next cycle.
- R3: A read of address 0 returns the value that `raw_rdat` had in the cycle the address was presented.
- R4: The 20-bit configuration value is split MSB word first. Address 1 holds bits 19:16, zero-extended in reads, with the upper four written bits discarded. Address 2 holds bits 15:8 and address 3 holds bits 7:0. A bus write to one of these words changes only that word.
- R5: `f0_q` always shows the stored 20-bit configuration value, updated in the cycle after a write.
- R6: A core write (`f1_we` or `f2_we` high) loads `f1_d` or `f2_d` into its register at the next edge. A bus write to address 5 also loads the control value. `f2_q` always shows the stored control value.
- R7: If a bus write to address 5 and `f2_we` occur in the same cycle, the stored value becomes `f2_d`.
- R8: A bus write to address 4 leaves the status value unchanged, as seen in a later read of address 4.
- R9: A read of address 5 returns zero, whatever the stored value.
- R10: After reset, the configuration value is 20'hA5C3E, the status value is 8'h81 and the control value is 8'h5A; `raw_stb` and `bus_rdat` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_adr | input | 4 | Bus word address |
| bus_we | input | 1 | Bus write enable |
| bus_wdat | input | 8 | Bus write data |
| bus_rdat | output | 8 | Bus read data, one cycle after address |
| raw_wdat | output | 8 | Pass-through write data to core |
| raw_stb | output | 1 | One-cycle strobe qualifying `raw_wdat` |
| raw_rdat | input | 8 | Core-supplied read value for address 0 |
| f0_q | output | 20 | Core view of the configuration value |
| f1_d | input | 8 | Core write data for the status value |
| f1_we | input | 1 | Core write enable for the status value |
| f2_q | output | 8 | Core view of the control value |
| f2_d | input | 8 | Core write data for the control value |
| f2_we | input | 1 | Core write enable for the control value |

## Verification
The hardest case to reach is a bus write and a core write landing on the control register in the same cycle. The control value is never readable from the bus, so the collision shows up only on `f2_q`. The stimulus deliberately aligns `f2_we` with a bus write to address 5, using two different data values. It then checks `f2_q`, and alongside it checks that a read of address 5 still returns zero. A long pseudo-random phase mixes all addresses with both core strobes, so collisions and partial updates of the split configuration word also occur in orders nobody chose by hand.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } acc_e;

  function automatic int word_count(input int width, input int dw);
    return (width + dw - 1) / dw;
  endfunction

  function automatic bit may_read(input acc_e a);
    return a != ACC_WO;
  endfunction

  function automatic bit may_write(input acc_e a);
    return a != ACC_RO;
  endfunction

endpackage

// File: rtl/csr_field.sv
module csr_field #(
  parameter int                  W       = 8,
  parameter int                  DW      = 8,
  parameter int                  AW      = 4,
  parameter int                  BASE    = 1,
  parameter logic [W-1:0]        RST     = '0,
  parameter csr_bank_pkg::acc_e  BUS_ACC = csr_bank_pkg::ACC_RW,
  parameter csr_bank_pkg::acc_e  DEV_ACC = csr_bank_pkg::ACC_RO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] adr,
  input  logic          we,
  input  logic [DW-1:0] wdat,
  output logic [DW-1:0] rd_word,
  input  logic [W-1:0]  dev_d,
  input  logic          dev_we,
  output logic [W-1:0]  dev_q
);
  import csr_bank_pkg::*;

  localparam int            NW     = word_count(W, DW);
  localparam int            PW     = NW * DW;
  localparam bit            BUS_RD = may_read(BUS_ACC);
  localparam bit            BUS_WR = may_write(BUS_ACC);
  localparam bit            DEV_RD = may_read(DEV_ACC);
  localparam bit            DEV_WR = may_write(DEV_ACC);
  localparam logic [AW-1:0] FIRST  = AW'(BASE);
  localparam logic [AW-1:0] LAST   = AW'(BASE + NW - 1);

  // word at offset idx from BASE holds bits starting here (MSB word first)
  function automatic int word_shift(input logic [AW-1:0] idx);
    return (NW - 1 - int'(idx)) * DW;
  endfunction

  logic [W-1:0]  q;
  logic [PW-1:0] qpad, mask, merged;
  logic [AW-1:0] widx;
  int            sh;
  logic          hit;
  logic          bus_wr;   // bus write event accepted by this field
  logic          dev_wr;   // core write event accepted by this field

  always_comb begin
    qpad    = PW'(q);
    hit     = (adr >= FIRST) && (adr <= LAST);
    widx    = adr - FIRST;
    sh      = word_shift(widx);
    bus_wr  = we && hit && BUS_WR;
    dev_wr  = dev_we && DEV_WR;
    mask    = PW'({DW{1'b1}}) << sh;
    merged  = (qpad & ~mask) | (PW'(wdat) << sh);
    rd_word = (hit && BUS_RD) ? DW'(qpad >> sh) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST;
    else if (dev_wr) q <= dev_d;
    else if (bus_wr) q <= merged[W-1:0];
  end

  generate
    if (DEV_RD) begin : g_dev_view
      assign dev_q = q;
    end else begin : g_dev_hidden
      assign dev_q = '0;
    end
  endgenerate

  // R7: a core write lands regardless of a simultaneous bus write
  p_core_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> (q == $past(dev_d)));

  generate
    if (!BUS_WR) begin : g_ro_check
      // R8: the bus cannot change a bus-read-only field
      p_bus_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_wr) |=> $stable(q));
    end
  endgenerate

endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int               DW     = 8,
  parameter int               AW     = 4,
  parameter int               F0_W   = 20,
  parameter logic [F0_W-1:0]  F0_RST = 20'hA5C3E,
  parameter logic [DW-1:0]    F1_RST = 8'h81,
  parameter logic [DW-1:0]    F2_RST = 8'h5A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_adr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdat,
  output logic [DW-1:0]   bus_rdat,
  output logic [DW-1:0]   raw_wdat,
  output logic            raw_stb,
  input  logic [DW-1:0]   raw_rdat,
  output logic [F0_W-1:0] f0_q,
  input  logic [DW-1:0]   f1_d,
  input  logic            f1_we,
  output logic [DW-1:0]   f2_q,
  input  logic [DW-1:0]   f2_d,
  input  logic            f2_we
);
  import csr_bank_pkg::*;

  localparam int            F0_NW = word_count(F0_W, DW);
  localparam int            F0_B  = 1;
  localparam int            F1_B  = F0_B + F0_NW;
  localparam int            F2_B  = F1_B + 1;
  localparam logic [AW-1:0] RAW_A = '0;
  localparam logic [AW-1:0] F2_A  = AW'(F2_B);

  logic [DW-1:0] f0_rd, f1_rd, f2_rd, raw_rd, rd_next;
  logic [DW-1:0] f1_q_unused;
  logic          raw_hit;   // bus write event on the pass-through register

  csr_field #(.W(F0_W), .DW(DW), .AW(AW), .BASE(F0_B), .RST(F0_RST),
              .BUS_ACC(ACC_RW), .DEV_ACC(ACC_RO)) u_f0 (
    .clk(clk), .rst_n(rst_n), .adr(bus_adr), .we(bus_we), .wdat(bus_wdat),
    .rd_word(f0_rd), .dev_d('0), .dev_we(1'b0), .dev_q(f0_q));

  csr_field #(.W(DW), .DW(DW), .AW(AW), .BASE(F1_B), .RST(F1_RST),
              .BUS_ACC(ACC_RO), .DEV_ACC(ACC_WO)) u_f1 (
    .clk(clk), .rst_n(rst_n), .adr(bus_adr), .we(bus_we), .wdat(bus_wdat),
    .rd_word(f1_rd), .dev_d(f1_d), .dev_we(f1_we), .dev_q(f1_q_unused));

  csr_field #(.W(DW), .DW(DW), .AW(AW), .BASE(F2_B), .RST(F2_RST),
              .BUS_ACC(ACC_WO), .DEV_ACC(ACC_RW)) u_f2 (
    .clk(clk), .rst_n(rst_n), .adr(bus_adr), .we(bus_we), .wdat(bus_wdat),
    .rd_word(f2_rd), .dev_d(f2_d), .dev_we(f2_we), .dev_q(f2_q));

  always_comb begin
    raw_hit = bus_we && (bus_adr == RAW_A);
    raw_rd  = (bus_adr == RAW_A) ? raw_rdat : '0;
    rd_next = raw_rd | f0_rd | f1_rd | f2_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdat <= '0;
      raw_stb  <= 1'b0;
      raw_wdat <= '0;
    end else begin
      bus_rdat <= rd_next;
      raw_stb  <= raw_hit;
      if (raw_hit) raw_wdat <= bus_wdat;
    end
  end

  // R2: write to the pass-through register gives strobe and data next cycle
  p_raw_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_adr == RAW_A) |=> (raw_stb && raw_wdat == $past(bus_wdat)));

  // R2: no write, no strobe
  p_raw_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_adr == RAW_A) |=> !raw_stb);

  // R3: pass-through read returns the core value of the address cycle
  p_raw_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_adr == RAW_A) |=> (bus_rdat == $past(raw_rdat)));

  // R9: bus-write-only register reads as zero
  p_wo_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_adr == F2_A) |=> (bus_rdat == '0));

  // R1: addresses past the map read as zero
  p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_adr > F2_A) |=> (bus_rdat == '0));

endmodule

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_adr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdat = '0;
  logic [7:0]  bus_rdat;
  logic [7:0]  raw_wdat;
  logic        raw_stb;
  logic [7:0]  raw_rdat = '0;
  logic [19:0] f0_q;
  logic [7:0]  f1_d = '0;
  logic        f1_we = 1'b0;
  logic [7:0]  f2_q;
  logic [7:0]  f2_d = '0;
  logic        f2_we = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [19:0] m_cfg;
  logic [7:0]  m_sts, m_ctl;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_adr(bus_adr), .bus_we(bus_we),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .raw_wdat(raw_wdat),
    .raw_stb(raw_stb), .raw_rdat(raw_rdat), .f0_q(f0_q), .f1_d(f1_d),
    .f1_we(f1_we), .f2_q(f2_q), .f2_d(f2_d), .f2_we(f2_we));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [3:0] a);
    if (a == 4'd0) return "R3";
    if (a >= 4'd1 && a <= 4'd3) return "R4";
    if (a == 4'd5) return "R9";
    return "R1";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One bus/core cycle: drive at negedge, check at the following negedge.
  task automatic step(input logic [3:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] rr, input logic s_we, input logic [7:0] s_d,
                      input logic c_we, input logic [7:0] c_d, input string tag);
    logic [7:0] e_rd;
    logic       e_stb;
    string      rtag;
    bus_adr = a; bus_we = we; bus_wdat = wd; raw_rdat = rr;
    f1_we = s_we; f1_d = s_d; f2_we = c_we; f2_d = c_d;
    case (a)
      4'd0:    e_rd = rr;
      4'd1:    e_rd = {4'h0, m_cfg[19:16]};
      4'd2:    e_rd = m_cfg[15:8];
      4'd3:    e_rd = m_cfg[7:0];
      4'd4:    e_rd = m_sts;
      default: e_rd = 8'h00;
    endcase
    e_stb = we && (a == 4'd0);
    if (we && a == 4'd1) m_cfg[19:16] = wd[3:0];
    if (we && a == 4'd2) m_cfg[15:8]  = wd;
    if (we && a == 4'd3) m_cfg[7:0]   = wd;
    if (s_we) m_sts = s_d;
    if (c_we) m_ctl = c_d;
    else if (we && a == 4'd5) m_ctl = wd;
    @(posedge clk);
    @(negedge clk);
    rtag = (tag == "") ? rd_tag(a) : tag;
    chk(bus_rdat == e_rd, rtag, "bus_rdat", 32'(bus_rdat), 32'(e_rd));
    chk(raw_stb == e_stb, "R2", "raw_stb", 32'(raw_stb), 32'(e_stb));
    if (e_stb) chk(raw_wdat == wd, "R2", "raw_wdat", 32'(raw_wdat), 32'(wd));
    chk(f0_q == m_cfg, "R5", "f0_q", 32'(f0_q), 32'(m_cfg));
    chk(f2_q == m_ctl, (tag == "") ? "R6" : tag, "f2_q", 32'(f2_q), 32'(m_ctl));
  endtask

  function automatic int unsigned next_rand(input int unsigned s);
    int unsigned x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_cfg = 20'hA5C3E; m_sts = 8'h81; m_ctl = 8'h5A;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(f0_q == 20'hA5C3E, "R10", "f0_q", 32'(f0_q), 32'h000A5C3E);
    chk(f2_q == 8'h5A, "R10", "f2_q", 32'(f2_q), 32'h5A);
    chk(raw_stb == 1'b0, "R10", "raw_stb", 32'(raw_stb), 0);
    chk(bus_rdat == 8'h00, "R10", "bus_rdat", 32'(bus_rdat), 0);
    rst_n = 1'b1;
    step(4'd4, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R10");
    // R1, R3, R4, R9: walk the whole address space
    for (int i = 0; i < 16; i++)
      step(4'(i), 0, 8'h00, 8'(8'h30 + i), 0, 8'h00, 0, 8'h00, "");
    // R2: pass-through write, then idle cycle
    step(4'd0, 1, 8'h3C, 8'h11, 0, 8'h00, 0, 8'h00, "R2");
    step(4'd7, 0, 8'h00, 8'h11, 0, 8'h00, 0, 8'h00, "R2");
    step(4'd0, 1, 8'hC4, 8'h22, 0, 8'h00, 0, 8'h00, "R2");
    step(4'd0, 1, 8'h5D, 8'h23, 0, 8'h00, 0, 8'h00, "R2");
    // R4, R5: split configuration writes, top word truncated
    step(4'd3, 1, 8'h12, 8'h00, 0, 8'h00, 0, 8'h00, "R5");
    step(4'd1, 1, 8'hF7, 8'h00, 0, 8'h00, 0, 8'h00, "R5");
    step(4'd2, 1, 8'h9B, 8'h00, 0, 8'h00, 0, 8'h00, "R5");
    for (int i = 1; i < 4; i++)
      step(4'(i), 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R4");
    // R8: bus write to status is ignored
    step(4'd4, 1, 8'hEE, 8'h00, 0, 8'h00, 0, 8'h00, "R8");
    step(4'd4, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R8");
    // R6: core writes status and control
    step(4'd6, 0, 8'h00, 8'h00, 1, 8'h4B, 1, 8'hA1, "R6");
    step(4'd4, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R6");
    // R6, R9: bus writes control, read of it returns zero
    step(4'd5, 1, 8'h77, 8'h00, 0, 8'h00, 0, 8'h00, "R6");
    step(4'd5, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R9");
    // R7: simultaneous bus and core write to control
    step(4'd5, 1, 8'h0F, 8'h00, 0, 8'h00, 1, 8'hD2, "R7");
    step(4'd5, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R7");
    // R8: bus write to status in the same cycle as a core write
    step(4'd4, 1, 8'h01, 8'h00, 1, 8'h6C, 0, 8'h00, "R8");
    step(4'd4, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "R8");
    // R1: mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      seed = next_rand(seed);
      r = seed;
      step(4'(r[3:0] % 8), r[4], r[15:8], r[23:16], r[5], r[31:24],
           r[6] & r[7], r[23:16] ^ r[31:24], "");
    end
    finish_run();
  end

endmodule